// File: doc/BRIEF.md
# Locked-Clock Dual-Domain FIFO

This block moves a stream of words from one clock domain to another when the two clocks share a frequency but not a fixed phase. Words go into a small dual-port store on write-clock edges. The read side presents the oldest unread word on its output without any request, so the output already holds valid data when the FIFO stops reporting empty.

Each domain keeps its own pointer, and that pointer has one extra wrap bit. A copy of each pointer reaches the other domain through a short ring of registers. The ring is written on every edge of the source clock and read on every edge of the destination clock, at an index that trails the write index by a fixed number of slots. No synchronizer flops are used. Each side compares its own pointer against the delayed copy of the far pointer. Because that copy is old, full and empty can stay set a little longer than needed, but they are never cleared too early.

Top module: `locked_clock_fifo`

## Requirements
- R1: A word on wr_data is stored on the write-clock edge where wr_en is high and wr_full is low, and the write pointer advances by exactly one.
- R2: When wr_en is high while wr_full is high, the write pointer does not move and the stored words are unchanged. Reading out afterwards returns only the earlier words, in order.
- R3: When rd_en is high while rd_empty is high, the read pointer does not move. The next word written is the next word read.
- R4: Whenever rd_empty is low, rd_data shows the oldest unread word. A read-clock edge with rd_en high and rd_empty low removes that word.
- R5: For any repeating pattern of write and read enables, every accepted word comes out exactly once and in the order it was accepted.
- R6: With no reads, wr_full rises on the write-clock cycle right after the DEPTH-th accepted write. A continuous burst of writes therefore stores exactly DEPTH words.
- R7: The flags are conservative. Unread words never exceed DEPTH, and rd_empty is never low when no unread word exists.
- R8: The clocks run at one frequency, and the read clock lags by less than one period. Reset is released on both sides in the same write period. Under these conditions, rd_empty falls 2 to RING_LAG+3 read cycles after a write into an empty FIFO. Likewise, wr_full falls 2 to RING_LAG+3 write cycles after a read from a full FIFO.
- R9: After reset, rd_empty is high and wr_full is low.
- R10: rd_empty rises on the read cycle right after the last unread word is removed, without waiting for any pointer transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write request for wr_data this cycle |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No room for another word, as seen from the write domain |
| rd_clk | input | 1 | Read-domain clock, same frequency as wr_clk |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Remove the word shown on rd_data |
| rd_data | output | DATA_W | Oldest unread word (first-word fall-through) |
| rd_empty | output | 1 | No unread word, as seen from the read domain |

## Verification
The bench builds the block with DEPTH=4, DATA_W=8, RING_SLOTS=4 and RING_LAG=2, and shifts the read clock 3 ns behind the write clock. With only four slots, the full boundary and the refusal of writes come up many times in every run. The bench sweeps all 256 pairs of 4-bit repeating write and read enable patterns, so the flags are exercised in every overlap of pointer-transfer delay and occupancy. The burst fill, the reads on an empty FIFO and the flag-release latencies in both directions are each measured once at their exact cycle.

// File: rtl/lcf_pkg.sv
package lcf_pkg;

    localparam int unsigned LCF_WIDTH_DEF = 8;
    localparam int unsigned LCF_DEPTH_DEF = 16;
    localparam int unsigned LCF_RING_DEF  = 4;
    localparam int unsigned LCF_LAG_DEF   = 2;

    // occupancy class seen by one side of the FIFO
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;

    // distance from lag pointer to lead pointer, modulo 2**pw
    function automatic logic [31:0] ptr_gap(input logic [31:0] lead,
                                            input logic [31:0] lag,
                                            input int unsigned pw);
        logic [31:0] mask;
        mask = (32'd1 << pw) - 32'd1;
        return (lead - lag) & mask;
    endfunction

    function automatic occ_e occ_classify(input logic [31:0] gap,
                                          input int unsigned depth);
        if (gap == 32'd0)
            return OCC_EMPTY;
        else if (gap >= depth)
            return OCC_FULL;
        else
            return OCC_PARTIAL;
    endfunction

endpackage

// File: rtl/lcf_xfer_ring.sv
// Carries a value from src_clk to dst_clk through a register ring.
// The ring is written every source cycle and read every destination
// cycle, with the read index trailing by LAG slots. SLOTS must be a
// power of two.
module lcf_xfer_ring #(
    parameter int unsigned W     = 5,
    parameter int unsigned SLOTS = 4,
    parameter int unsigned LAG   = 2
) (
    input  logic         src_clk,
    input  logic         src_rst,
    input  logic [W-1:0] src_val,
    input  logic         dst_clk,
    input  logic         dst_rst,
    output logic [W-1:0] dst_val
);
    localparam int unsigned IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [IW-1:0] RD_START = IW'(SLOTS - LAG);

    logic [W-1:0]  slot_q [SLOTS];
    logic [IW-1:0] src_idx;
    logic [IW-1:0] dst_idx;

    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            src_idx <= '0;
            for (int i = 0; i < int'(SLOTS); i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            slot_q[src_idx] <= src_val;
            src_idx         <= src_idx + 1'b1;
        end
    end

    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            dst_idx <= RD_START;
            dst_val <= '0;
        end else begin
            dst_val <= slot_q[dst_idx];
            dst_idx <= dst_idx + 1'b1;
        end
    end

endmodule

// File: rtl/lcf_store.sv
// Dual-port word store: synchronous write, combinational read.
module lcf_store #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cell_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/lcf_ptr_ctrl.sv
// One side's pointer and flag. PRODUCER=1 is the write side and
// blocks on full. PRODUCER=0 is the read side and blocks on empty.
module lcf_ptr_ctrl
    import lcf_pkg::*;
#(
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned PW       = 5,
    parameter bit          PRODUCER = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [PW-1:0] far_ptr,
    output logic [PW-1:0] ptr_q,
    output logic          blocked,
    output logic          step
);
    logic [31:0] gap;
    occ_e        occ;

    generate
        if (PRODUCER) begin : g_prod
            assign gap     = ptr_gap(32'(ptr_q), 32'(far_ptr), PW);
            assign occ     = occ_classify(gap, DEPTH);
            assign blocked = (occ == OCC_FULL);
        end else begin : g_cons
            assign gap     = ptr_gap(32'(far_ptr), 32'(ptr_q), PW);
            assign occ     = occ_classify(gap, DEPTH);
            assign blocked = (occ == OCC_EMPTY);
        end
    endgenerate

    assign step = req && !blocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (step) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/locked_clock_fifo.sv
module locked_clock_fifo
    import lcf_pkg::*;
#(
    parameter int unsigned DATA_W     = LCF_WIDTH_DEF,
    parameter int unsigned DEPTH      = LCF_DEPTH_DEF,
    parameter int unsigned RING_SLOTS = LCF_RING_DEF,
    parameter int unsigned RING_LAG   = LCF_LAG_DEF
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;

    logic [PW-1:0] wptr_w;
    logic [PW-1:0] rptr_r;
    logic [PW-1:0] rptr_at_w;
    logic [PW-1:0] wptr_at_r;
    logic          push_ok;
    logic          pop_ok;

    lcf_ptr_ctrl #(.DEPTH(DEPTH), .PW(PW), .PRODUCER(1'b1)) u_wside (
        .clk     (wr_clk),
        .rst     (wr_rst),
        .req     (wr_en),
        .far_ptr (rptr_at_w),
        .ptr_q   (wptr_w),
        .blocked (wr_full),
        .step    (push_ok)
    );

    lcf_ptr_ctrl #(.DEPTH(DEPTH), .PW(PW), .PRODUCER(1'b0)) u_rside (
        .clk     (rd_clk),
        .rst     (rd_rst),
        .req     (rd_en),
        .far_ptr (wptr_at_r),
        .ptr_q   (rptr_r),
        .blocked (rd_empty),
        .step    (pop_ok)
    );

    lcf_xfer_ring #(.W(PW), .SLOTS(RING_SLOTS), .LAG(RING_LAG)) u_w2r (
        .src_clk (wr_clk),
        .src_rst (wr_rst),
        .src_val (wptr_w),
        .dst_clk (rd_clk),
        .dst_rst (rd_rst),
        .dst_val (wptr_at_r)
    );

    lcf_xfer_ring #(.W(PW), .SLOTS(RING_SLOTS), .LAG(RING_LAG)) u_r2w (
        .src_clk (rd_clk),
        .src_rst (rd_rst),
        .src_val (rptr_r),
        .dst_clk (wr_clk),
        .dst_rst (wr_rst),
        .dst_val (rptr_at_w)
    );

    lcf_store #(.W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .wclk  (wr_clk),
        .we    (push_ok),
        .waddr (wptr_w[AW-1:0]),
        .wdata (wr_data),
        .raddr (rptr_r[AW-1:0]),
        .rdata (rd_data)
    );

endmodule

// File: rtl/lcf_checker.sv
module lcf_checker #(
    parameter int unsigned DEPTH = 16
) (
    input logic                       wr_clk,
    input logic                       wr_rst,
    input logic                       wr_en,
    input logic                       wr_full,
    input logic [$clog2(DEPTH):0]     wptr,
    input logic [$clog2(DEPTH):0]     rptr_seen,
    input logic                       rd_clk,
    input logic                       rd_rst,
    input logic                       rd_en,
    input logic                       rd_empty,
    input logic [$clog2(DEPTH):0]     rptr,
    input logic [$clog2(DEPTH):0]     wptr_seen
);
    localparam int unsigned PW = $clog2(DEPTH) + 1;

    assert_push_advances_R1: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && !wr_full) |=> (wptr == PW'($past(wptr) + 1'b1)));

    assert_full_blocks_R2: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && wr_full) |=> (wptr == $past(wptr)));

    assert_empty_blocks_R3: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && rd_empty) |=> (rptr == $past(rptr)));

    assert_no_overfill_R7: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (32'(PW'(wptr - rptr_seen)) <= DEPTH));

    assert_no_phantom_R7: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (32'(PW'(wptr_seen - rptr)) <= DEPTH));

endmodule

bind locked_clock_fifo lcf_checker #(.DEPTH(DEPTH)) u_chk (
    .wr_clk    (wr_clk),
    .wr_rst    (wr_rst),
    .wr_en     (wr_en),
    .wr_full   (wr_full),
    .wptr      (wptr_w),
    .rptr_seen (rptr_at_w),
    .rd_clk    (rd_clk),
    .rd_rst    (rd_rst),
    .rd_en     (rd_en),
    .rd_empty  (rd_empty),
    .rptr      (rptr_r),
    .wptr_seen (wptr_at_r)
);

// File: tb/sim_locked_clock_fifo.sv
module sim_locked_clock_fifo;
    localparam int unsigned W  = 8;
    localparam int unsigned D  = 4;
    localparam int unsigned RS = 4;
    localparam int unsigned RL = 2;

    logic         wr_clk = 1'b0;
    logic         rd_clk = 1'b0;
    logic         wr_rst = 1'b1;
    logic         rd_rst = 1'b1;
    logic         wr_en  = 1'b0;
    logic         rd_en  = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         wr_full;
    logic [W-1:0] rd_data;
    logic         rd_empty;

    int           checks = 0;
    int           fails  = 0;
    logic [W-1:0] model[$];
    logic [W-1:0] next_val = '0;

    locked_clock_fifo #(.DATA_W(W), .DEPTH(D), .RING_SLOTS(RS), .RING_LAG(RL)) u0 (
        .wr_clk   (wr_clk),
        .wr_rst   (wr_rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_full  (wr_full),
        .rd_clk   (rd_clk),
        .rd_rst   (rd_rst),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_empty (rd_empty)
    );

    // 100 MHz on both sides, read clock 3 ns behind
    always #5 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #5 rd_clk = ~rd_clk;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        wr_rst = 1'b1;
        rd_rst = 1'b1;
        wr_en  = 1'b0;
        rd_en  = 1'b0;
        repeat (3) @(negedge wr_clk);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        model.delete();
    endtask

    // one write-clock cycle, decided at the falling edge
    task automatic wr_cycle(input bit en, output bit took);
        @(negedge wr_clk);
        wr_en   = en;
        wr_data = next_val;
        took    = en && !wr_full;
        if (took) begin
            if (model.size() >= D)
                check(1'b0, "R7", "accepted beyond capacity", model.size() + 1, D);
            model.push_back(next_val);
            next_val = next_val + 1'b1;
        end
    endtask

    // one read-clock cycle, decided at the falling edge
    task automatic rd_cycle(input bit en, input string req);
        @(negedge rd_clk);
        rd_en = en;
        if (!rd_empty) begin
            if (model.size() == 0) begin
                check(1'b0, "R7", "not empty with nothing unread", 0, 1);
            end else if (en) begin
                logic [W-1:0] exp;
                exp = model.pop_front();
                check(rd_data == exp, req, "rd_data", int'(rd_data), int'(exp));
            end
        end
    endtask

    bit done = 1'b0;
    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit took;
        int acc;
        int lat;

        do_reset();
        @(negedge rd_clk);
        check(rd_empty == 1'b1, "R9", "rd_empty after reset", int'(rd_empty), 1);
        check(wr_full == 1'b0, "R9", "wr_full after reset", int'(wr_full), 0);

        // R6/R2: continuous burst stores exactly DEPTH words
        acc = 0;
        for (int i = 0; i < int'(D) + 3; i++) begin
            wr_cycle(1'b1, took);
            if (took) acc++;
        end
        wr_cycle(1'b0, took);
        check(acc == int'(D), "R6", "words taken from burst", acc, D);
        check(wr_full == 1'b1, "R6", "wr_full after burst", int'(wr_full), 1);
        repeat (8) wr_cycle(1'b0, took);
        check(wr_full == 1'b1, "R2", "wr_full held without reads", int'(wr_full), 1);

        // R8: full release latency after one read
        rd_cycle(1'b1, "R4");
        @(negedge rd_clk);
        rd_en = 1'b0;
        lat = 0;
        for (int i = 0; i < 10 && wr_full; i++) begin
            @(negedge wr_clk);
            lat++;
        end
        check(lat >= 2 && lat <= int'(RL) + 3, "R8", "write cycles until wr_full fell", lat, RL + 3);

        // drain the remaining D-1 words: R2 order, R4 data
        for (int i = 0; i < int'(D) - 1; i++) rd_cycle(1'b1, "R2");
        @(negedge rd_clk);
        check(rd_empty == 1'b1, "R10", "rd_empty right after last pop", int'(rd_empty), 1);
        check(model.size() == 0, "R2", "words left in model", model.size(), 0);

        // R3: reads on empty are ignored
        rd_en = 1'b1;
        repeat (4) rd_cycle(1'b1, "R3");
        rd_cycle(1'b0, "R3");
        check(rd_empty == 1'b1, "R3", "rd_empty after reads on empty", int'(rd_empty), 1);

        // R8: empty release latency, then R3 data check
        wr_cycle(1'b1, took);
        wr_cycle(1'b0, took);
        lat = 0;
        for (int i = 0; i < 10 && rd_empty; i++) begin
            @(negedge rd_clk);
            lat++;
        end
        check(lat >= 2 && lat <= int'(RL) + 3, "R8", "read cycles until rd_empty fell", lat, RL + 3);
        rd_cycle(1'b1, "R3");
        rd_cycle(1'b0, "R3");
        check(model.size() == 0, "R3", "word after empty reads consumed", model.size(), 0);

        // R5: sweep all repeating 4-bit enable pattern pairs
        for (int wm = 0; wm < 16; wm++) begin
            for (int rm = 0; rm < 16; rm++) begin
                logic [3:0] wpat;
                logic [3:0] rpat;
                wpat = 4'(wm);
                rpat = 4'(rm);
                fork
                    begin
                        bit t;
                        for (int i = 0; i < 20; i++) wr_cycle(wpat[i % 4], t);
                        wr_cycle(1'b0, t);
                    end
                    begin
                        for (int i = 0; i < 20; i++) rd_cycle(rpat[i % 4], "R5");
                        rd_cycle(1'b0, "R5");
                    end
                join
                repeat (12) rd_cycle(1'b1, "R5");
                rd_cycle(1'b0, "R5");
                check(model.size() == 0 && rd_empty == 1'b1, "R5",
                      "unread after drain", model.size(), 0);
                @(negedge wr_clk);
                check(wr_full == 1'b0, "R8", "wr_full after drain", int'(wr_full), 0);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule